// File: doc/BRIEF.md
# Dual-Channel DAC Serial Register Interface

This block is the digital front end of a two-channel 16-bit converter. A host shifts a serial frame in on a serial clock while an active-low chip select is held low. When chip select returns high, the frame's two leading address bits pick which of the two channel input registers take its 16 data bits. A separate active-low load strobe, level-sensitive and independent of the serial clock, copies both input registers into the two DAC registers whose values drive the converter cores. Each channel is therefore double-buffered: new codes can be staged on both channels and then made live together.

All pins are treated as asynchronous to the system clock and pass through synchronizer stages before use. An active-low clear pin and the synchronous active-high power-on reset both force every input and DAC register to a reset code. A static select pin chooses that code: zero scale or midscale. The two DAC register values are the block's registered outputs.

Top module: `dual_dac_serial_if`

## Requirements
- R1: While `cs_n` is low, each rising edge of `sclk` shifts `sdi` into an 18-bit shift register, most significant bit first. The first two bits shifted form the channel address, with address bit 0 (the second bit sent) selecting channel A and address bit 1 (the first bit sent) selecting channel B. The last 16 bits are the data word, most significant bit first.
- R2: While `cs_n` is high, `sclk` edges shift nothing and the bit count is held at zero, so toggling `sclk` between frames does not disturb the next frame.
- R3: A rising edge of `cs_n` after exactly 18 `sclk` rising edges writes the data word into the input registers selected by the address: 01 writes A, 10 writes B, 11 writes both, and 00 writes neither.
- R4: A rising edge of `cs_n` after any count other than 18 (including 0 and more than 18) leaves both input registers unchanged.
- R5: While `ldac_n` is low, both DAC registers copy their input registers on every clock, so a frame completed while the strobe is held low reaches the outputs without a further strobe. `cs_n` does not gate this copy.
- R6: While `ldac_n` is high, the DAC register outputs do not change when input registers are written.
- R7: While `clr_n` is low, both input registers and both DAC registers are set to the reset code: 0x0000 when `mid_sel` is 0 and 0x8000 when `mid_sel` is 1.
- R8: The power-on reset `rst` sets all four registers to the same `mid_sel`-selected reset code.
- R9: The clear has priority: a frame transfer or a low `ldac_n` coinciding with a low `clr_n` leaves every register at the reset code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| sclk | input | 1 | Serial shift clock, rising edge active |
| sdi | input | 1 | Serial data in |
| cs_n | input | 1 | Active-low chip select; rising edge ends a frame |
| ldac_n | input | 1 | Active-low level-sensitive load strobe |
| clr_n | input | 1 | Active-low clear to the reset code |
| mid_sel | input | 1 | Static reset-code select: 0 zero scale, 1 midscale |
| dac_a | output | 16 | Channel A DAC register value |
| dac_b | output | 16 | Channel B DAC register value |

## Verification
The bench sweeps every address code against a spread of data words, including all-zeros, all-ones and single-bit patterns, and checks both outputs before and after the load strobe. A design that decoded the address bits in the wrong order would update the wrong channel, and one with a broken double buffer would show the new code before the strobe. Frames of 0, 1, 17 and 19 bits are sent to catch a length check that is off by one or that wraps its counter. Serial clocks toggled with chip select high catch a counter that is not cleared, and the clear is applied together with a strobe and a completed frame under both reset codes; a design with the wrong priority would leave a transferred word in place.

// File: rtl/dual_dac_pkg.sv
package dual_dac_pkg;

  // Channel address carried in the two leading frame bits.
  typedef enum logic [1:0] {
    ADDR_NONE = 2'b00,
    ADDR_A    = 2'b01,
    ADDR_B    = 2'b10,
    ADDR_BOTH = 2'b11
  } chan_addr_e;

  localparam int ADDR_BITS = 2;
  localparam int CH_A      = 0;
  localparam int CH_B      = 1;

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int   STAGES   = 2,
  parameter logic RST_LEVEL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) begin
          chain[s] <= RST_LEVEL;
        end else if (s == 0) begin
          chain[s] <= d;
        end else begin
          chain[s] <= chain[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/serial_frame_rx.sv
module serial_frame_rx #(
  parameter int FRAME_W = 18
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sclk_s,
  input  logic               sdi_s,
  input  logic               cs_n_s,
  output logic [FRAME_W-1:0] frame,
  output logic               frame_done
);

  localparam int CNT_MAX = FRAME_W + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [FRAME_W-1:0] shift_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               sclk_prev;
  logic               cs_prev;
  logic               sclk_rise;
  logic               cs_rise;

  assign sclk_rise = sclk_s & ~sclk_prev;
  assign cs_rise   = cs_n_s & ~cs_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_prev <= 1'b0;
      cs_prev   <= 1'b1;
    end else begin
      sclk_prev <= sclk_s;
      cs_prev   <= cs_n_s;
    end
  end

  // Counter saturates one past the frame length so long frames stay invalid.
  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q <= '0;
      cnt_q   <= '0;
    end else if (cs_n_s) begin
      cnt_q <= '0;
    end else if (sclk_rise) begin
      shift_q <= {shift_q[FRAME_W-2:0], sdi_s};
      if (cnt_q != CNT_W'(CNT_MAX)) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign frame      = shift_q;
  assign frame_done = cs_rise && (cnt_q == CNT_W'(FRAME_W));

  a_r2_cnt_clear: assert property (@(posedge clk) disable iff (rst)
    cs_n_s |=> (cnt_q == '0))
    else $error("R2: bit count not cleared while chip select high");

  a_r1_cnt_step: assert property (@(posedge clk) disable iff (rst)
    (!cs_n_s && sclk_rise && (cnt_q < CNT_W'(CNT_MAX))) |=> (cnt_q == $past(cnt_q) + 1'b1))
    else $error("R1: bit count did not advance on serial clock");

  a_r1_shift_in: assert property (@(posedge clk) disable iff (rst)
    (!cs_n_s && sclk_rise) |=> (shift_q[0] == $past(sdi_s)))
    else $error("R1: serial bit not captured");

endmodule

// File: rtl/channel_bank.sv
module channel_bank #(
  parameter int DATA_W = 16,
  parameter int NUM_CH = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          clr_req,
  input  logic                          mid_sel,
  input  logic                          commit,
  input  logic [NUM_CH-1:0]             sel,
  input  logic [DATA_W-1:0]             data,
  input  logic                          ldac_req,
  output logic [NUM_CH-1:0][DATA_W-1:0] dac_o
);

  localparam logic [DATA_W-1:0] MID_CODE = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] rst_code;
  logic [NUM_CH-1:0][DATA_W-1:0] in_q;
  logic [NUM_CH-1:0][DATA_W-1:0] dac_q;

  assign rst_code = mid_sel ? MID_CODE : '0;

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      // Clear outranks both the frame transfer and the load strobe.
      always_ff @(posedge clk) begin
        if (rst || clr_req) begin
          in_q[g]  <= rst_code;
          dac_q[g] <= rst_code;
        end else begin
          if (commit && sel[g]) begin
            in_q[g] <= data;
          end
          if (ldac_req) begin
            dac_q[g] <= in_q[g];
          end
        end
      end

      a_r7_clear_code: assert property (@(posedge clk) disable iff (rst)
        clr_req |=> ((in_q[g] == $past(rst_code)) && (dac_q[g] == $past(rst_code))))
        else $error("R7: clear did not apply reset code");

      a_r5_dac_follow: assert property (@(posedge clk) disable iff (rst)
        (!clr_req && ldac_req) |=> (dac_q[g] == $past(in_q[g])))
        else $error("R5: DAC register did not copy input register");

      a_r6_dac_hold: assert property (@(posedge clk) disable iff (rst)
        (!clr_req && !ldac_req) |=> $stable(dac_q[g]))
        else $error("R6: DAC register moved without load strobe");

      a_r4_input_hold: assert property (@(posedge clk) disable iff (rst)
        (!clr_req && !commit) |=> $stable(in_q[g]))
        else $error("R4: input register moved without a valid frame");
    end
  endgenerate

  assign dac_o = dac_q;

endmodule

// File: rtl/dual_dac_serial_if.sv
module dual_dac_serial_if #(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              cs_n,
  input  logic              ldac_n,
  input  logic              clr_n,
  input  logic              mid_sel,
  output logic [DATA_W-1:0] dac_a,
  output logic [DATA_W-1:0] dac_b
);

  import dual_dac_pkg::*;

  localparam int NUM_CH  = ADDR_BITS;
  localparam int FRAME_W = ADDR_BITS + DATA_W;

  logic sclk_s, sdi_s, cs_n_s, ldac_n_s, clr_n_s;

  pin_sync #(.STAGES(SYNC_STAGES), .RST_LEVEL(1'b0)) u_sync_sclk (
    .clk(clk), .rst(rst), .d(sclk),   .q(sclk_s));
  pin_sync #(.STAGES(SYNC_STAGES), .RST_LEVEL(1'b0)) u_sync_sdi (
    .clk(clk), .rst(rst), .d(sdi),    .q(sdi_s));
  pin_sync #(.STAGES(SYNC_STAGES), .RST_LEVEL(1'b1)) u_sync_cs (
    .clk(clk), .rst(rst), .d(cs_n),   .q(cs_n_s));
  pin_sync #(.STAGES(SYNC_STAGES), .RST_LEVEL(1'b1)) u_sync_ldac (
    .clk(clk), .rst(rst), .d(ldac_n), .q(ldac_n_s));
  pin_sync #(.STAGES(SYNC_STAGES), .RST_LEVEL(1'b1)) u_sync_clr (
    .clk(clk), .rst(rst), .d(clr_n),  .q(clr_n_s));

  logic [FRAME_W-1:0] frame;
  logic               frame_done;

  serial_frame_rx #(.FRAME_W(FRAME_W)) u_rx (
    .clk        (clk),
    .rst        (rst),
    .sclk_s     (sclk_s),
    .sdi_s      (sdi_s),
    .cs_n_s     (cs_n_s),
    .frame      (frame),
    .frame_done (frame_done)
  );

  chan_addr_e                    addr;
  logic [NUM_CH-1:0][DATA_W-1:0] dac_vals;

  assign addr = chan_addr_e'(frame[FRAME_W-1 -: ADDR_BITS]);

  channel_bank #(.DATA_W(DATA_W), .NUM_CH(NUM_CH)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .clr_req  (~clr_n_s),
    .mid_sel  (mid_sel),
    .commit   (frame_done),
    .sel      (addr),
    .data     (frame[DATA_W-1:0]),
    .ldac_req (~ldac_n_s),
    .dac_o    (dac_vals)
  );

  assign dac_a = dac_vals[CH_A];
  assign dac_b = dac_vals[CH_B];

  a_r9_clear_wins: assert property (@(posedge clk) disable iff (rst)
    (!clr_n_s && !ldac_n_s) |=> ((dac_a == dac_b) && (dac_a[DATA_W-2:0] == '0)))
    else $error("R9: load strobe overrode clear");

endmodule

// File: tb/dual_dac_serial_if_test.sv
`timescale 1ns/1ps
module dual_dac_serial_if_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, sdi = 1'b0, cs_n = 1'b1, ldac_n = 1'b1, clr_n = 1'b1, mid_sel = 1'b0;
  logic [15:0] dac_a, dac_b;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [15:0] m_in_a, m_in_b, m_dac_a, m_dac_b;

  always #5 clk = ~clk;

  dual_dac_serial_if uut (
    .clk(clk), .rst(rst), .sclk(sclk), .sdi(sdi), .cs_n(cs_n),
    .ldac_n(ldac_n), .clr_n(clr_n), .mid_sel(mid_sel),
    .dac_a(dac_a), .dac_b(dac_b)
  );

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_outs(input string tag);
    check({tag, " dac_a"}, dac_a, m_dac_a);
    check({tag, " dac_b"}, dac_b, m_dac_b);
  endtask

  // Shift nbits bits of vec, most significant of those first.
  task automatic shift_bits(input logic [31:0] vec, input int nbits);
    cs_n = 1'b0;
    wait_clks(5);
    for (int i = nbits - 1; i >= 0; i--) begin
      sdi = vec[i];
      wait_clks(5);
      sclk = 1'b1;
      wait_clks(5);
      sclk = 1'b0;
    end
    wait_clks(5);
    cs_n = 1'b1;
    wait_clks(6);
  endtask

  task automatic send_frame(input logic [1:0] addr, input logic [15:0] data);
    shift_bits({14'd0, addr, data}, 18);
    if (addr[0]) m_in_a = data;
    if (addr[1]) m_in_b = data;
  endtask

  task automatic strobe;
    ldac_n = 1'b0;
    wait_clks(6);
    ldac_n = 1'b1;
    wait_clks(6);
    m_dac_a = m_in_a;
    m_dac_b = m_in_b;
  endtask

  task automatic set_model(input logic [15:0] v);
    m_in_a = v; m_in_b = v; m_dac_a = v; m_dac_b = v;
  endtask

  task automatic power_on(input logic mid);
    rst = 1'b1;
    mid_sel = mid;
    wait_clks(4);
    rst = 1'b0;
    wait_clks(2);
    set_model(mid ? 16'h8000 : 16'h0000);
  endtask

  initial begin
    logic [15:0] rc;
    for (int mid = 0; mid < 2; mid++) begin
      power_on(mid[0]);
      rc = mid[0] ? 16'h8000 : 16'h0000;
      check_outs("R8 power-on code");

      // Sweep every address with a spread of data words.
      for (int a = 0; a < 4; a++) begin
        for (int k = 0; k < 6; k++) begin
          logic [15:0] d;
          case (k)
            0: d = 16'h0000;
            1: d = 16'hFFFF;
            2: d = 16'h0001 << (a * 4 + mid);
            3: d = 16'hA5A5 ^ 16'(a);
            default: d = 16'((k * 16'h2493) ^ (a * 16'h1111) ^ 16'h5A5A);
          endcase
          send_frame(a[1:0], d);
          check_outs("R6 outputs held before strobe");
          strobe();
          check_outs("R3 R1 address decode after strobe");
        end
      end

      // Wrong frame lengths must leave the input registers alone.
      send_frame(2'b11, 16'h3C3C);
      strobe();
      shift_bits({14'd0, 2'b11, 16'hDEAD}, 17);
      strobe();
      check_outs("R4 17-bit frame discarded");
      shift_bits({13'd0, 2'b11, 16'hBEEF, 1'b1}, 19);
      strobe();
      check_outs("R4 19-bit frame discarded");
      shift_bits(32'h1, 1);
      strobe();
      check_outs("R4 1-bit frame discarded");
      shift_bits(32'h0, 0);
      strobe();
      check_outs("R4 empty frame discarded");

      // Serial clocks with chip select high must not disturb the next frame.
      sdi = 1'b1;
      for (int t = 0; t < 5; t++) begin
        sclk = 1'b1; wait_clks(5); sclk = 1'b0; wait_clks(5);
      end
      send_frame(2'b01, 16'h1357);
      send_frame(2'b10, 16'h2468);
      strobe();
      check_outs("R2 clocks ignored while deselected");

      // Strobe held low: frames reach the outputs directly.
      ldac_n = 1'b0;
      wait_clks(6);
      send_frame(2'b11, 16'h0F0F);
      m_dac_a = m_in_a; m_dac_b = m_in_b;
      check_outs("R5 level-sensitive load");
      send_frame(2'b10, 16'h7001);
      m_dac_b = m_in_b;
      check_outs("R5 second frame while strobe low");
      ldac_n = 1'b1;
      wait_clks(6);

      // Clear sets everything to the reset code.
      clr_n = 1'b0;
      wait_clks(6);
      set_model(rc);
      check_outs("R7 clear code");
      clr_n = 1'b1;
      wait_clks(6);
      strobe();
      check_outs("R7 input registers cleared");

      // Clear together with a frame and a low strobe.
      send_frame(2'b11, 16'h4444);
      strobe();
      clr_n = 1'b0;
      ldac_n = 1'b0;
      shift_bits({14'd0, 2'b11, 16'h9999}, 18);
      set_model(rc);
      check_outs("R9 clear beats frame and strobe");
      clr_n = 1'b1;
      wait_clks(6);
      ldac_n = 1'b1;
      wait_clks(6);
      check_outs("R9 reset code after clear release");
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule